// File: doc/BRIEF.md
# Configurable Logic Cell

This block models one programmable logic cell of the kind found in look-up-table based programmable logic. Two 4-input tables, F and G, each hold sixteen bits and are addressed by their own 4-bit input. A third, 3-input table H combines the F result, the G result and one extra input. Either 4-input table can instead serve as a 16x1 RAM that is written on the rising edge of the cell clock. Two storage elements, X and Y, take their data from a configurable source. Each one works either as an edge flip-flop or as a transparent latch, with its own clock polarity, its own set/reset behaviour and its own clock-enable handling.

The whole cell runs in one system clock domain. The cell clock `cell_clk` is a data input that is sampled on every system clock, so flip-flop edges and latch transparency are detected from samples and act on the system clock edge where they are seen. The cell is set up through a 68-bit serial chain. The F table comes first in the chain, then the G table, then a 36-bit control word. Four auxiliary inputs are steered by configuration to the H-table extra input, the data input DIN, set/reset and clock enable.

Top module: `lcell_top`

## Requirements
- R1: While `cfg_en` is 1, each system clock edge shifts `cfg_di` into a 68-bit chain `{ctl[35:0], G[15:0], F[15:0]}` at bit 0 and moves every bit one place up. After 68 shifts, the first bit sent sits in ctl[35]. The control word layout is: ctl[35] F RAM mode, ctl[34] G RAM mode, ctl[33:26] H table, ctl[25:24] X select, ctl[23:22] Y select, ctl[21:20] X data select, ctl[19:18] Y data select, ctl[17:16] H-input steer, ctl[15:14] DIN steer, ctl[13:12] set/reset steer, ctl[11:10] enable steer, ctl[9:5] X storage setup, ctl[4:0] Y storage setup. Each storage setup is {latch, invert clock, async set/reset, set/reset value, ignore enable}.
- R2: In logic mode, the F result is F[f_in] and the G result is G[g_in], both combinational.
- R3: The H result is H[{h1, G result, F result}], where h1 is the auxiliary input chosen by the H-input steer.
- R4: The select codes for x_o, y_o and the storage data inputs are 0 for F, 1 for G, 2 for H and 3 for DIN.
- R5: In RAM mode, when `ram_we` is 1 on a sample where `cell_clk` rises, DIN is written to the table at the table's own address. No write happens without that rising sample, and a table in logic mode is never written.
- R6: In flip-flop mode, the element loads its data on the sample where `cell_clk` rises, or where it falls if the clock is inverted. It holds at all other times.
- R7: In latch mode, the element follows its data on every system clock while `cell_clk` is high, or low if the clock is inverted. It holds while the clock is at the other level.
- R8: When set/reset is 1, the element goes to its set/reset value. In async setup this happens on the next system clock. In sync setup it happens only when the element would otherwise load, and it happens whether or not the enable is 1.
- R9: When the enable input is 0 and the ignore-enable bit is 0, the element holds. When the ignore-enable bit is 1, the enable input has no effect.
- R10: While `cfg_en` is 1, neither storage element changes. Configuration loading therefore leaves xq_o and yq_o as they were.
- R11: A system clock edge with `rst` at 1 clears the chain, both tables and both storage elements.
- R12: Each steer field is a 2-bit index n that selects c_in[n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_di | input | 1 | Configuration serial data |
| f_in | input | 4 | F table address |
| g_in | input | 4 | G table address |
| c_in | input | 4 | Auxiliary control inputs |
| ram_we | input | 1 | RAM-mode write enable |
| cell_clk | input | 1 | Cell clock, sampled by clk |
| x_o | output | 1 | Combinational X output |
| y_o | output | 1 | Combinational Y output |
| xq_o | output | 1 | X storage element output |
| yq_o | output | 1 | Y storage element output |

## Verification
The assertions check on every cycle that the storage elements keep their value whenever a hold condition applies. Those conditions are a configuration load, enable low, and no active edge in flip-flop mode. The assertions also check that an async set/reset lands on the next clock, and that the tables and control word change only through their permitted paths. The values themselves can only be shown by the bench scenarios. Those values are the table lookups against random contents, H combinations, select codes, RAM write-then-read against a stored array, edge and level polarity, the ordering of sync set/reset against enable, and the retention of stored values across a reconfiguration.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  parameter int LUT_K = 4;
  localparam int LUT_DEPTH = 1 << LUT_K;
  parameter int N_AUX = 4;
  localparam int AUX_W = $clog2(N_AUX);
  localparam int H_IN = 3;
  localparam int H_DEPTH = 1 << H_IN;
  localparam int N_LUT = 2;
  localparam int N_STOR = 2;

  localparam logic [1:0] SRC_F   = 2'd0;
  localparam logic [1:0] SRC_G   = 2'd1;
  localparam logic [1:0] SRC_H   = 2'd2;
  localparam logic [1:0] SRC_DIN = 2'd3;

  typedef struct packed {
    logic latch;
    logic kinv;
    logic sr_async;
    logic sr_val;
    logic ec_off;
  } stor_cfg_t;

  typedef struct packed {
    logic                 f_ram;
    logic                 g_ram;
    logic [H_DEPTH-1:0]   h_tab;
    logic [1:0]           x_sel;
    logic [1:0]           y_sel;
    logic [1:0]           xd_sel;
    logic [1:0]           yd_sel;
    logic [AUX_W-1:0]     h1_sel;
    logic [AUX_W-1:0]     din_sel;
    logic [AUX_W-1:0]     sr_sel;
    logic [AUX_W-1:0]     ec_sel;
    stor_cfg_t            xs;
    stor_cfg_t            ys;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/lcell_cfg.sv
module lcell_cfg
  import lcell_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic shift_in,
  output ctl_t ctl_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)           ctl_q <= '0;
    else if (shift_en) ctl_q <= {ctl_q[CTL_W-2:0], shift_in};
  end

  assign ctl_o = ctl_q;

  // control word moves only through the chain
  p_ctl_stable_r1: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(ctl_q));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic             shift_out,
  input  logic             ram_mode,
  input  logic             wr_strobe,
  input  logic             wr_data,
  input  logic [LUT_K-1:0] addr,
  output logic             fn_o
);
  logic [LUT_DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst)                         mem <= '0;
    else if (shift_en)               mem <= {mem[LUT_DEPTH-2:0], shift_in};
    else if (ram_mode && wr_strobe)  mem[addr] <= wr_data;
  end

  assign fn_o      = mem[addr];
  assign shift_out = mem[LUT_DEPTH-1];

  // a table in logic mode keeps its contents outside configuration
  p_logic_table_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !ram_mode) |=> $stable(mem));

  // RAM mode writes only on a strobe
  p_ram_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !wr_strobe) |=> $stable(mem));
endmodule

// File: rtl/lcell_store.sv
module lcell_store
  import lcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hold,
  input  logic      kin,
  input  logic      kq,
  input  logic      d,
  input  logic      sr,
  input  logic      ec,
  input  stor_cfg_t cfg,
  output logic      q
);
  logic lvl_now, lvl_prev, edge_hit, evt, en_ok;

  assign lvl_now  = kin ^ cfg.kinv;
  assign lvl_prev = kq ^ cfg.kinv;
  assign edge_hit = lvl_now & ~lvl_prev;
  assign evt      = cfg.latch ? lvl_now : edge_hit;
  assign en_ok    = ec | cfg.ec_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (!hold) begin
      if (sr && (cfg.sr_async || evt)) q <= cfg.sr_val;
      else if (evt && en_ok)           q <= d;
    end
  end

  p_hold_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(q));

  p_async_sr_r8: assert property (@(posedge clk) disable iff (rst)
    (!hold && sr && cfg.sr_async) |=> (q == $past(cfg.sr_val)));

  p_ec_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!hold && !sr && !ec && !cfg.ec_off) |=> $stable(q));

  p_no_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!hold && !sr && !cfg.latch && !edge_hit) |=> $stable(q));
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_di,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic [N_AUX-1:0] c_in,
  input  logic             ram_we,
  input  logic             cell_clk,
  output logic             x_o,
  output logic             y_o,
  output logic             xq_o,
  output logic             yq_o
);
  ctl_t ctl;
  logic kq;
  logic wr_strobe;
  logic h1, din, sr, ec, h_out;

  logic [N_LUT-1:0]  lut_si, lut_so, lut_ram, lut_out;
  logic [LUT_K-1:0]  lut_addr [N_LUT];
  stor_cfg_t         st_cfg   [N_STOR];
  logic [1:0]        st_sel   [N_STOR];
  logic [N_STOR-1:0] st_d, st_q;

  function automatic logic pick(input logic [1:0] s, input logic f,
                                input logic g, input logic h, input logic dv);
    case (s)
      SRC_F:   return f;
      SRC_G:   return g;
      SRC_H:   return h;
      default: return dv;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) kq <= 1'b0;
    else     kq <= cell_clk;
  end

  assign wr_strobe = ram_we & cell_clk & ~kq;

  assign h1  = c_in[ctl.h1_sel];
  assign din = c_in[ctl.din_sel];
  assign sr  = c_in[ctl.sr_sel];
  assign ec  = c_in[ctl.ec_sel];

  assign lut_si[0]   = cfg_di;
  assign lut_si[1]   = lut_so[0];
  assign lut_ram[0]  = ctl.f_ram;
  assign lut_ram[1]  = ctl.g_ram;
  assign lut_addr[0] = f_in;
  assign lut_addr[1] = g_in;

  for (genvar i = 0; i < N_LUT; i++) begin : g_lut
    lcell_lut u_lut (
      .clk      (clk),
      .rst      (rst),
      .shift_en (cfg_en),
      .shift_in (lut_si[i]),
      .shift_out(lut_so[i]),
      .ram_mode (lut_ram[i]),
      .wr_strobe(wr_strobe),
      .wr_data  (din),
      .addr     (lut_addr[i]),
      .fn_o     (lut_out[i])
    );
  end

  lcell_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .shift_en(cfg_en),
    .shift_in(lut_so[N_LUT-1]),
    .ctl_o   (ctl)
  );

  assign h_out = ctl.h_tab[{h1, lut_out[1], lut_out[0]}];

  assign x_o = pick(ctl.x_sel, lut_out[0], lut_out[1], h_out, din);
  assign y_o = pick(ctl.y_sel, lut_out[0], lut_out[1], h_out, din);

  assign st_cfg[0] = ctl.xs;
  assign st_cfg[1] = ctl.ys;
  assign st_sel[0] = ctl.xd_sel;
  assign st_sel[1] = ctl.yd_sel;

  for (genvar j = 0; j < N_STOR; j++) begin : g_store
    assign st_d[j] = pick(st_sel[j], lut_out[0], lut_out[1], h_out, din);
    lcell_store u_store (
      .clk (clk),
      .rst (rst),
      .hold(cfg_en),
      .kin (cell_clk),
      .kq  (kq),
      .d   (st_d[j]),
      .sr  (sr),
      .ec  (ec),
      .cfg (st_cfg[j]),
      .q   (st_q[j])
    );
  end

  assign xq_o = st_q[0];
  assign yq_o = st_q[1];

  p_cfg_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> ($stable(xq_o) && $stable(yq_o)));
endmodule

// File: tb/lcell_top_tb_top.sv
module lcell_top_tb_top;
  localparam logic [1:0] S_F = 2'd0, S_G = 2'd1, S_H = 2'd2, S_D = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1, cfg_en = 1'b0, cfg_di = 1'b0, ram_we = 1'b0, cell_clk = 1'b0;
  logic [3:0] f_in = '0, g_in = '0, c_in = '0;
  logic x_o, y_o, xq_o, yq_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  lcell_top dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_di(cfg_di),
    .f_in(f_in), .g_in(g_in), .c_in(c_in), .ram_we(ram_we),
    .cell_clk(cell_clk), .x_o(x_o), .y_o(y_o), .xq_o(xq_o), .yq_o(yq_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [35:0] mkctl(
    input logic fr, input logic gr, input logic [7:0] ht,
    input logic [1:0] xs, input logic [1:0] ys, input logic [1:0] xd,
    input logic [1:0] yd, input logic [1:0] h1, input logic [1:0] dn,
    input logic [1:0] sr, input logic [1:0] ec,
    input logic [4:0] xst, input logic [4:0] yst);
    return {fr, gr, ht, xs, ys, xd, yd, h1, dn, sr, ec, xst, yst};
  endfunction

  task automatic load(input logic [35:0] ctl, input logic [15:0] gm,
                      input logic [15:0] fm);
    logic [67:0] v;
    v = {ctl, gm, fm};
    cfg_en = 1'b1;
    for (int i = 67; i >= 0; i--) begin
      cfg_di = v[i];
      step();
    end
    cfg_en = 1'b0;
  endtask

  task automatic do_reset;
    rst = 1'b1; cell_clk = 1'b0; ram_we = 1'b0; cfg_en = 1'b0;
    c_in = '0; f_in = '0; g_in = '0;
    step(); step();
    rst = 1'b0;
    step();
  endtask

  task automatic t_reset;
    do_reset();
    chk("R11 xq", xq_o, 1'b0);
    chk("R11 yq", yq_o, 1'b0);
    chk("R11 x", x_o, 1'b0);
    chk("R11 y", y_o, 1'b0);
    load(mkctl(0, 0, 8'h00, S_F, S_G, S_F, S_G, 0, 0, 0, 0, 5'd0, 5'd0),
         16'h0000, 16'h0020);
    f_in = 4'd5; g_in = 4'd5; step();
    chk("R1 F bit5", x_o, 1'b1);
    f_in = 4'd4; step();
    chk("R1 F bit4", x_o, 1'b0);
    do_reset();
    f_in = 4'd5; step();
    chk("R11 table cleared", x_o, 1'b0);
  endtask

  task automatic t_logic;
    do_reset();
    for (int tr = 0; tr < 3; tr++) begin
      logic [15:0] fm, gm;
      logic [7:0]  ht;
      logic [1:0]  hs;
      fm = 16'($urandom); gm = 16'($urandom); ht = 8'($urandom); hs = 2'(tr + 1);
      load(mkctl(0, 0, ht, S_F, S_G, S_F, S_G, hs, 0, 0, 0, 5'd0, 5'd0), gm, fm);
      for (int a = 0; a < 16; a++) begin
        logic [3:0] fa, ga;
        fa = 4'(a); ga = ~4'(a);
        f_in = fa; g_in = ga; step();
        chk("R2 F lookup", x_o, fm[fa]);
        chk("R2 G lookup", y_o, gm[ga]);
      end
      load(mkctl(0, 0, ht, S_H, S_G, S_F, S_G, hs, 0, 0, 0, 5'd0, 5'd0), gm, fm);
      for (int a = 0; a < 16; a++) begin
        for (int h = 0; h < 2; h++) begin
          logic [3:0] fa, ga;
          logic [3:0] cc;
          fa = 4'(a); ga = 4'(a) ^ 4'h5;
          cc = 4'($urandom); cc[hs] = h[0];
          f_in = fa; g_in = ga; c_in = cc; step();
          chk("R3 H combine R12", x_o, ht[{h[0], gm[ga], fm[fa]}]);
        end
      end
    end
  endtask

  task automatic t_outsel;
    do_reset();
    load(mkctl(0, 0, 8'h00, S_D, S_D, S_F, S_G, 0, 2'd2, 0, 0, 5'd0, 5'd0),
         16'h0, 16'h0);
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pv;
      pv = 4'(p);
      c_in = pv; step();
      chk("R12 DIN steer", x_o, pv[2]);
      chk("R4 y DIN code", y_o, pv[2]);
    end
    load(mkctl(0, 0, 8'h00, S_G, S_F, S_F, S_G, 0, 0, 0, 0, 5'd0, 5'd0),
         16'hAAAA, 16'h00FF);
    f_in = 4'hA; g_in = 4'h3; step();
    chk("R4 x G code", x_o, 1'b1);
    chk("R4 y F code", y_o, 1'b0);
  endtask

  task automatic t_ram;
    logic [15:0] refm;
    logic [15:0] gm;
    do_reset();
    refm = '0; gm = 16'h5A5A;
    load(mkctl(1, 0, 8'h00, S_F, S_G, S_F, S_G, 0, 0, 0, 0, 5'd0, 5'd0), gm, 16'h0);
    for (int k = 0; k < 40; k++) begin
      logic [3:0] a;
      logic db, we;
      a = 4'($urandom); db = 1'($urandom); we = (k < 16) ? 1'b1 : 1'($urandom);
      if (k < 16) a = 4'(k);
      f_in = a; g_in = a; c_in = {3'b000, db}; ram_we = we; cell_clk = 1'b1;
      step();
      cell_clk = 1'b0; ram_we = 1'b0;
      step();
      if (we) refm[a] = db;
    end
    for (int a = 0; a < 16; a++) begin
      logic [3:0] aa;
      aa = 4'(a);
      f_in = aa; g_in = aa; step();
      chk("R5 RAM readback", x_o, refm[aa]);
      chk("R5 logic table untouched", y_o, gm[aa]);
    end
    f_in = 4'd3; c_in = {3'b000, ~refm[3]}; ram_we = 1'b1;
    step(); step();
    ram_we = 1'b0; step();
    chk("R5 no write without edge", x_o, refm[3]);
  endtask

  task automatic t_ff;
    do_reset();
    load(mkctl(0, 0, 8'h00, S_F, S_G, S_D, S_D, 0, 2'd0, 2'd2, 2'd3,
               5'b00000, 5'b01001), 16'h0, 16'h0);
    c_in = 4'b1001; step();
    chk("R6 no edge x", xq_o, 1'b0);
    chk("R6 no edge y", yq_o, 1'b0);
    cell_clk = 1'b1; step();
    chk("R6 rise x", xq_o, 1'b1);
    chk("R6 rise ignored inverted y", yq_o, 1'b0);
    c_in = 4'b1000; step();
    chk("R6 hold high x", xq_o, 1'b1);
    c_in = 4'b1001; cell_clk = 1'b0; step();
    chk("R6 fall y", yq_o, 1'b1);
    chk("R6 fall ignored x", xq_o, 1'b1);
    c_in = 4'b1000; cell_clk = 1'b1; step();
    chk("R6 rise x load 0", xq_o, 1'b0);
    chk("R6 hold y", yq_o, 1'b1);
    c_in = 4'b0000; cell_clk = 1'b0; step();
    chk("R9 enable ignored y", yq_o, 1'b0);
    c_in = 4'b0001; cell_clk = 1'b1; step();
    chk("R9 enable low holds x", xq_o, 1'b0);
    cell_clk = 1'b0; step();
    c_in = 4'b1001; cell_clk = 1'b1; step();
    chk("R9 enable high loads x", xq_o, 1'b1);
  endtask

  task automatic t_latch;
    do_reset();
    load(mkctl(0, 0, 8'h00, S_F, S_G, S_D, S_D, 0, 2'd0, 2'd2, 2'd3,
               5'b10001, 5'b11001), 16'h0, 16'h0);
    cell_clk = 1'b1; c_in = 4'b0001; step();
    chk("R7 transparent x", xq_o, 1'b1);
    chk("R7 opaque y", yq_o, 1'b0);
    c_in = 4'b0000; step();
    chk("R7 follow x", xq_o, 1'b0);
    c_in = 4'b0001; step();
    chk("R7 follow x again", xq_o, 1'b1);
    cell_clk = 1'b0; c_in = 4'b0000; step();
    chk("R7 closed x", xq_o, 1'b1);
    c_in = 4'b0001; step();
    chk("R7 inverted open y", yq_o, 1'b1);
    chk("R7 still closed x", xq_o, 1'b1);
    c_in = 4'b0000; step();
    chk("R7 inverted follow y", yq_o, 1'b0);
  endtask

  task automatic t_sr;
    do_reset();
    load(mkctl(0, 0, 8'h00, S_F, S_G, S_D, S_D, 0, 2'd0, 2'd2, 2'd3,
               5'b00010, 5'b00110), 16'h0, 16'h0);
    c_in = 4'b1100; step();
    chk("R8 sync waits x", xq_o, 1'b0);
    chk("R8 async sets y", yq_o, 1'b1);
    c_in = 4'b0100; cell_clk = 1'b1; step();
    chk("R8 sync at edge despite enable low", xq_o, 1'b1);
    c_in = 4'b0000; cell_clk = 1'b0; step();
    load(mkctl(0, 0, 8'h00, S_F, S_G, S_D, S_D, 0, 2'd0, 2'd2, 2'd3,
               5'b00000, 5'b00100), 16'h0, 16'h0);
    chk("R10 x kept over reload", xq_o, 1'b1);
    chk("R10 y kept over reload", yq_o, 1'b1);
    c_in = 4'b0100; step();
    chk("R8 sync clear waits x", xq_o, 1'b1);
    chk("R8 async clear y", yq_o, 1'b0);
    cell_clk = 1'b1; step();
    chk("R8 sync clear at edge x", xq_o, 1'b0);
  endtask

  task automatic t_cfg_hold;
    do_reset();
    load(mkctl(0, 0, 8'h00, S_F, S_G, S_D, S_D, 0, 2'd0, 2'd2, 2'd3,
               5'b00001, 5'b00001), 16'h0, 16'h0);
    c_in = 4'b0001; cell_clk = 1'b1; step();
    chk("R6 setup x", xq_o, 1'b1);
    chk("R6 setup y", yq_o, 1'b1);
    cell_clk = 1'b0; step();
    c_in = 4'b0100;
    load(mkctl(0, 0, 8'h00, S_F, S_G, S_D, S_D, 0, 2'd0, 2'd2, 2'd3,
               5'b00001, 5'b00101), 16'hFFFF, 16'hFFFF);
    chk("R10 load keeps x", xq_o, 1'b1);
    chk("R10 load keeps y", yq_o, 1'b1);
    step();
    chk("R10 new setup active y", yq_o, 1'b0);
    chk("R10 x unaffected", xq_o, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_logic();
    t_outsel();
    t_ram();
    t_ff();
    t_latch();
    t_sr();
    t_cfg_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule